// File: doc/BRIEF.md
# Latched Tri-Port Bus Exchanger

This block joins one bidirectional A port to two bidirectional B ports (B1 and B2) of equal width, 12 bits by default. It is meant for a processor bus that fronts two memory banks, one even and one odd. Words from A can be parked in either B bank's outgoing holding stage, or in both at once, so that writes interleave. Words returning from the banks are held in two separate holding stages. A select input chooses which of these two reaches A, so reads are multiplexed.

Each of the four holding stages is a transparent latch cell with its own enable. While the enable is high, the cell's output follows its input. When the enable goes low, the cell keeps the last word it saw. Every tristate pad is split into an `_in`, an `_out` and an `_oe` signal. The active-low enable inputs set the `_oe` outputs, one per port and independently of each other. This lets one B bank be written while the other is read.

Each latch cell is a small two-state machine:
- Its states are `CELL_OPEN` (enable high, output equals input) and `CELL_HOLD` (enable low, output equals the stored word).
- The transition OPEN→HOLD is the capture: the stored word is the input seen at the last clock edge with the enable high.
- The transition HOLD→OPEN releases the cell.

The `STYLE` parameter chooses how the cells are built. The default is a clocked register with a transparent bypass; the alternative is true level-sensitive latches.

Top module: `tri_port_xchg`

## Requirements
- R1: A word on `a_in` can be loaded into the A→B1 cell, the A→B2 cell, or both in the same cycle. Each B port then presents its own stored word on its `_out`, independently of the other.
- R2: While a cell's enable is high (`CELL_OPEN`), its output equals its input within the same cycle. This includes input changes between clock edges.
- R3: While a cell's enable is low (`CELL_HOLD`), its output is the input value sampled at the last rising clock edge at which the enable was high. Later input changes do not affect the output.
- R4: `a_out` carries the B1→A cell output when `sel_b1` is 1, and the B2→A cell output when `sel_b1` is 0.
- R5: `a_oe`, `b1_oe` and `b2_oe` are 1 exactly when `oe_a_n`, `oe_b1_n` and `oe_b2_n` respectively are 0, each independent of the others. `_out` values are presented regardless of the enable.
- R6: While `rst_n` is low, all three `_oe` outputs are 0 and all four cells are cleared to zero. After release, cells whose enable is low still present zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register-based cell variant |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Value seen on the A pad |
| a_out | output | W | Value the A pad drives when enabled |
| a_oe | output | 1 | A pad driver enable |
| b1_in | input | W | Value seen on the B1 pad |
| b1_out | output | W | Value the B1 pad drives when enabled |
| b1_oe | output | 1 | B1 pad driver enable |
| b2_in | input | W | Value seen on the B2 pad |
| b2_out | output | W | Value the B2 pad drives when enabled |
| b2_oe | output | 1 | B2 pad driver enable |
| le_a_b1 | input | 1 | Enable of the A→B1 cell, high = open |
| le_a_b2 | input | 1 | Enable of the A→B2 cell, high = open |
| le_b1_a | input | 1 | Enable of the B1→A cell, high = open |
| le_b2_a | input | 1 | Enable of the B2→A cell, high = open |
| sel_b1 | input | 1 | Read select: 1 = B1→A cell, 0 = B2→A cell |
| oe_a_n | input | 1 | Active-low A driver enable request |
| oe_b1_n | input | 1 | Active-low B1 driver enable request |
| oe_b2_n | input | 1 | Active-low B2 driver enable request |

## Verification
The main function is tried in three patterns.
- An interleaved write sequence loads B1 and B2 through separate enable pulses while later A values keep changing. This separates a cell that really holds from one that tracks its input, and shows that loading one bank leaves the other bank's word unchanged.
- A read pattern captures different words from the two banks and then toggles `sel_b1` with both cells closed. This exposes a swapped or stuck select and a read cell that still follows its pad.
- A mixed cycle writes B1 while B2 is transparent toward A, followed by a simultaneous load of both write cells. This shows that the four enables and three driver enables act independently.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

    typedef enum logic {
        STYLE_FLOP_BYPASS = 1'b0,
        STYLE_LEVEL_LATCH = 1'b1
    } latch_style_e;

    typedef enum logic {
        CELL_HOLD = 1'b0,
        CELL_OPEN = 1'b1
    } cell_state_e;

    localparam int NUM_CELLS = 4;
    localparam int CELL_A_B1 = 0;
    localparam int CELL_A_B2 = 1;
    localparam int CELL_B1_A = 2;
    localparam int CELL_B2_A = 3;

endpackage

// File: rtl/xchg_latch_cell.sv
module xchg_latch_cell
    import xchg_pkg::*;
#(
    parameter int           W     = 12,
    parameter latch_style_e STYLE = STYLE_FLOP_BYPASS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STYLE == STYLE_FLOP_BYPASS) begin : g_flop
            cell_state_e  mode;
            logic [W-1:0] held_q;

            always_comb begin
                mode = en ? CELL_OPEN : CELL_HOLD;
            end

            // storage: sample while open, keep while holding
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    held_q <= '0;
                end else if (mode == CELL_OPEN) begin
                    held_q <= d;
                end
            end

            // output: bypass while open
            always_comb begin
                unique case (mode)
                    CELL_OPEN: q = d;
                    CELL_HOLD: q = held_q;
                    default:   q = held_q;
                endcase
            end
        end else begin : g_latch
            logic [W-1:0] lat_q;

            always_latch begin
                if (!rst_n) begin
                    lat_q = '0;
                end else if (en) begin
                    lat_q = d;
                end
            end

            assign q = lat_q;
        end
    endgenerate

endmodule

// File: rtl/xchg_read_mux.sv
module xchg_read_mux #(
    parameter int W = 12
) (
    input  logic         sel_b1,
    input  logic [W-1:0] from_b1,
    input  logic [W-1:0] from_b2,
    output logic [W-1:0] to_a
);

    always_comb begin
        unique case (sel_b1)
            1'b1:    to_a = from_b1;
            1'b0:    to_a = from_b2;
            default: to_a = from_b2;
        endcase
    end

endmodule

// File: rtl/xchg_oe_ctrl.sv
module xchg_oe_ctrl #(
    parameter int NPORT = 3
) (
    input  logic             rst_n,
    input  logic [NPORT-1:0] oe_req_n,
    output logic [NPORT-1:0] oe
);

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            assign oe[p] = rst_n & ~oe_req_n[p];
        end
    endgenerate

endmodule

// File: rtl/tri_port_xchg.sv
module tri_port_xchg
    import xchg_pkg::*;
#(
    parameter int           W     = 12,
    parameter latch_style_e STYLE = STYLE_FLOP_BYPASS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b1_in,
    output logic [W-1:0] b1_out,
    output logic         b1_oe,
    input  logic [W-1:0] b2_in,
    output logic [W-1:0] b2_out,
    output logic         b2_oe,
    input  logic         le_a_b1,
    input  logic         le_a_b2,
    input  logic         le_b1_a,
    input  logic         le_b2_a,
    input  logic         sel_b1,
    input  logic         oe_a_n,
    input  logic         oe_b1_n,
    input  logic         oe_b2_n
);

    localparam int NPORT = 3;

    logic [NUM_CELLS-1:0] cell_en;
    logic [W-1:0]         cell_d [NUM_CELLS];
    logic [W-1:0]         cell_q [NUM_CELLS];
    logic [NPORT-1:0]     oe_req_n;
    logic [NPORT-1:0]     oe_vec;

    always_comb begin
        cell_en[CELL_A_B1] = le_a_b1;
        cell_en[CELL_A_B2] = le_a_b2;
        cell_en[CELL_B1_A] = le_b1_a;
        cell_en[CELL_B2_A] = le_b2_a;
        cell_d[CELL_A_B1]  = a_in;
        cell_d[CELL_A_B2]  = a_in;
        cell_d[CELL_B1_A]  = b1_in;
        cell_d[CELL_B2_A]  = b2_in;
    end

    generate
        for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
            xchg_latch_cell #(
                .W     (W),
                .STYLE (STYLE)
            ) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (cell_en[c]),
                .d     (cell_d[c]),
                .q     (cell_q[c])
            );
        end
    endgenerate

    xchg_read_mux #(
        .W (W)
    ) u_mux (
        .sel_b1  (sel_b1),
        .from_b1 (cell_q[CELL_B1_A]),
        .from_b2 (cell_q[CELL_B2_A]),
        .to_a    (a_out)
    );

    assign b1_out = cell_q[CELL_A_B1];
    assign b2_out = cell_q[CELL_A_B2];

    assign oe_req_n = {oe_b2_n, oe_b1_n, oe_a_n};

    xchg_oe_ctrl #(
        .NPORT (NPORT)
    ) u_oe (
        .rst_n    (rst_n),
        .oe_req_n (oe_req_n),
        .oe       (oe_vec)
    );

    assign a_oe  = oe_vec[0];
    assign b1_oe = oe_vec[1];
    assign b2_oe = oe_vec[2];

endmodule

// File: rtl/tri_port_xchg_chk.sv
module tri_port_xchg_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b1_in,
    input logic [W-1:0] b1_out,
    input logic         b1_oe,
    input logic [W-1:0] b2_in,
    input logic [W-1:0] b2_out,
    input logic         b2_oe,
    input logic         le_a_b1,
    input logic         le_a_b2,
    input logic         le_b1_a,
    input logic         le_b2_a,
    input logic         sel_b1,
    input logic         oe_a_n,
    input logic         oe_b1_n,
    input logic         oe_b2_n
);

    assert_b1_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        le_a_b1 |-> (b1_out == a_in));

    assert_b2_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        le_a_b2 |-> (b2_out == a_in));

    assert_b1_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(le_a_b1) && $past(rst_n)) |-> (b1_out == $past(a_in)));

    assert_b2_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_a_b2 && $past(!le_a_b2) && $past(rst_n)) |-> $stable(b2_out));

    assert_sel_b1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b1 && le_b1_a) |-> (a_out == b1_in));

    assert_sel_b2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_b1 && le_b2_a) |-> (a_out == b2_in));

    assert_oe_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n |-> !a_oe) and (oe_b1_n |-> !b1_oe) and (oe_b2_n |-> !b2_oe));

    always_comb begin
        if (rst_n === 1'b0) begin
            assert_reset_oe_R6: assert (!a_oe && !b1_oe && !b2_oe);
        end
    end

endmodule

bind tri_port_xchg tri_port_xchg_chk #(.W(W)) u_chk (.*);

// File: tb/tri_port_xchg_bench.sv
module tri_port_xchg_bench;

    localparam int W     = 12;
    localparam int NROW  = 12;
    localparam int VW    = 8 + 6 * W + 3;
    localparam int LIMIT = 5000;

    // row: ctrl[8] {le_a_b1,le_a_b2,le_b1_a,le_b2_a,sel_b1,oe_a_n,oe_b1_n,oe_b2_n},
    //      a_in, b1_in, b2_in, exp a_out, exp b1_out, exp b2_out, exp {a_oe,b1_oe,b2_oe}
    localparam logic [VW-1:0] VECS [NROW] = '{
        {8'b0000_0111, 12'h123, 12'h456, 12'h789, 12'h000, 12'h000, 12'h000, 3'b000},
        {8'b1000_0101, 12'hA11, 12'h456, 12'h789, 12'h000, 12'hA11, 12'h000, 3'b010},
        {8'b0100_0100, 12'hB22, 12'h456, 12'h789, 12'h000, 12'hA11, 12'hB22, 3'b011},
        {8'b0000_0100, 12'hC33, 12'h456, 12'h789, 12'h000, 12'hA11, 12'hB22, 3'b011},
        {8'b0011_1011, 12'hC33, 12'hD44, 12'hE55, 12'hD44, 12'hA11, 12'hB22, 3'b100},
        {8'b0000_1011, 12'hC33, 12'h111, 12'h222, 12'hD44, 12'hA11, 12'hB22, 3'b100},
        {8'b0000_0011, 12'hC33, 12'h111, 12'h222, 12'hE55, 12'hA11, 12'hB22, 3'b100},
        {8'b0000_1111, 12'hC33, 12'h111, 12'h222, 12'hD44, 12'hA11, 12'hB22, 3'b000},
        {8'b1001_0101, 12'h777, 12'h111, 12'hF66, 12'hF66, 12'h777, 12'hB22, 3'b010},
        {8'b0000_0011, 12'h777, 12'h111, 12'h333, 12'hF66, 12'h777, 12'hB22, 3'b100},
        {8'b1100_0100, 12'hABC, 12'h111, 12'h333, 12'hF66, 12'hABC, 12'hABC, 3'b011},
        {8'b0000_1100, 12'h000, 12'h111, 12'h333, 12'hD44, 12'hABC, 12'hABC, 3'b011}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b1_in, b2_in;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_oe, b1_oe, b2_oe;
    logic         le_a_b1, le_a_b2, le_b1_a, le_b2_a, sel_b1;
    logic         oe_a_n, oe_b1_n, oe_b2_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tri_port_xchg u_tri_port_xchg (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_in    (a_in),
        .a_out   (a_out),
        .a_oe    (a_oe),
        .b1_in   (b1_in),
        .b1_out  (b1_out),
        .b1_oe   (b1_oe),
        .b2_in   (b2_in),
        .b2_out  (b2_out),
        .b2_oe   (b2_oe),
        .le_a_b1 (le_a_b1),
        .le_a_b2 (le_a_b2),
        .le_b1_a (le_b1_a),
        .le_b2_a (le_b2_a),
        .sel_b1  (sel_b1),
        .oe_a_n  (oe_a_n),
        .oe_b1_n (oe_b1_n),
        .oe_b2_n (oe_b2_n)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > LIMIT) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, LIMIT);
                summary();
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        a_in = '0; b1_in = '0; b2_in = '0;
        le_a_b1 = 1'b1; le_a_b2 = 1'b1; le_b1_a = 1'b1; le_b2_a = 1'b1;
        sel_b1 = 1'b0;
        oe_a_n = 1'b0; oe_b1_n = 1'b0; oe_b2_n = 1'b0;
        a_in = 12'h5C5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #5;
        // R6: enables requested, yet all drivers off in reset
        chk("R6 a_oe in reset", {11'd0, a_oe}, 12'd0);
        chk("R6 b1_oe in reset", {11'd0, b1_oe}, 12'd0);
        chk("R6 b2_oe in reset", {11'd0, b2_oe}, 12'd0);
        le_a_b1 = 1'b0; le_a_b2 = 1'b0; le_b1_a = 1'b0; le_b2_a = 1'b0;
        oe_a_n = 1'b1; oe_b1_n = 1'b1; oe_b2_n = 1'b1;
        #1;
        chk("R6 b1_out cleared", b1_out, 12'h000);
        chk("R6 a_out cleared", a_out, 12'h000);
        @(negedge clk);
        rst_n = 1'b1;

        // vector walk: R1 (rows 10-11), R3 hold, R4 select, R5 enables
        for (int r = 0; r < NROW; r++) begin
            @(negedge clk);
            {le_a_b1, le_a_b2, le_b1_a, le_b2_a, sel_b1, oe_a_n, oe_b1_n, oe_b2_n} = VECS[r][VW-1 -: 8];
            a_in  = VECS[r][VW-9 -: W];
            b1_in = VECS[r][VW-9-W -: W];
            b2_in = VECS[r][VW-9-2*W -: W];
            #5;
            chk($sformatf("R4 a_out row %0d", r), a_out, VECS[r][3+3*W-1 -: W]);
            chk($sformatf("R1/R3 b1_out row %0d", r), b1_out, VECS[r][3+2*W-1 -: W]);
            chk($sformatf("R1/R3 b2_out row %0d", r), b2_out, VECS[r][3+W-1 -: W]);
            chk($sformatf("R5 oe row %0d", r), {9'd0, a_oe, b1_oe, b2_oe}, {9'd0, VECS[r][2:0]});
        end

        // R2: open cell follows input changes between edges
        @(negedge clk);
        le_a_b1 = 1'b1; le_a_b2 = 1'b0; le_b1_a = 1'b0; le_b2_a = 1'b0;
        a_in = 12'h5A5;
        #2;
        chk("R2 b1 follows first", b1_out, 12'h5A5);
        a_in = 12'hA5A;
        #2;
        chk("R2 b1 follows second", b1_out, 12'hA5A);
        chk("R2 b2 closed unaffected", b2_out, 12'hABC);

        // R3: close, then disturb input
        @(negedge clk);
        le_a_b1 = 1'b0;
        a_in = 12'h0F0;
        #5;
        chk("R3 b1 holds captured", b1_out, 12'hA5A);

        // R6: mid-run reset clears cells and drivers
        @(negedge clk);
        oe_b1_n = 1'b0;
        rst_n = 1'b0;
        #5;
        chk("R6 b1_out after reset", b1_out, 12'h000);
        chk("R6 b1_oe during reset", {11'd0, b1_oe}, 12'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk("R6 b2_out zero after release", b2_out, 12'h000);
        chk("R5 b1_oe after release", {11'd0, b1_oe}, 12'd1);

        done = 1'b1;
        summary();
    end

endmodule